// File: doc/BRIEF.md
# Synchronous Character Sync Hunter

This block sits at the front of a synchronous serial receiver. It takes one data bit per clock, qualified by a bit-valid strobe, and finds where characters begin. Until it has found a boundary it hunts: it compares the most recent bits against a programmed pattern, or it waits for an external active-low sync pin. Once a boundary is found it stays synchronised and delivers an assembled character at a fixed interval of bit times. It keeps doing this until it is told to restart the hunt.

Four modes share one engine. The single-pattern mode matches a 6- or 8-bit sync character. The double-pattern mode matches a 12- or 16-bit concatenation of two registers. The flag mode watches continuously for a frame flag and realigns on every flag. The external mode lets a pin supply the boundary, and a rate field picks one of three variants: pin only, pin or pattern, or flag framing in which the pin acts as a received flag. In the single-pattern mode, characters equal to the secondary register that fall on a character boundary can be dropped.

Top module: `sync_hunter`

## Requirements
- R1: In mode 0, bits enter least-significant first and `sync_ok` rises in the clock after the valid bit that makes the latest 8 bits equal `sync_pri` (or the latest 6 bits equal `sync_pri[5:0]` when `len6`=1). No earlier window sets it.
- R2: In mode 1, the match pattern is `sync_pri` received first followed by `sync_sec` (16 bits), or their low 6 bits each (12 bits) when `len6`=1. The primary part alone does not set `sync_ok`.
- R3: Once synchronised, each run of 8 valid bits (6 with `len6`=1) after the boundary gives a one-clock `char_vld` in the clock after its last bit. The first received bit is `char_out[0]`, and in 6-bit operation `char_out[7:6]` is 0.
- R4: In mode 0 with `strip_en`=1, a boundary character equal to `sync_sec` (its low 6 bits when `len6`=1) raises no `char_vld`. In other modes such characters are delivered.
- R5: In mode 2, every valid bit that completes an 8-bit match with `sync_pri` gives exactly one clock of `flag_pulse`, sets `sync_ok` and restarts the bit count. The flag is not delivered as a character, and hunting for flags continues while synchronised.
- R6: In mode 3 with `rate_sel` 0 or 1, a valid bit taken while `sync_n`=0 sets the boundary after that bit, and a pattern match alone does not.
- R7: In mode 3 with `rate_sel`=2, either `sync_n`=0 on a valid bit or a match with `sync_pri` sets the boundary.
- R8: In mode 3 with `rate_sel`=3, the receiver uses flag framing. A valid bit with `sync_n`=0 acts as a received flag (`flag_pulse`, realign, no character), and a pattern flag also counts.
- R9: In modes 0, 1 and 2, `rate_sel` has no effect.
- R10: Reset and a `hunt_restart` pulse clear the shift history and the bit count, and drop `sync_ok`. Characters are not delivered again until a new boundary is found.
- R11: In modes 0, 1 and 3 with `rate_sel` below 3, a pattern that recurs after sync is delivered as data and causes no realignment.
- R12: Clocks with `bit_vld`=0 shift nothing, count nothing and raise neither `char_vld` nor `flag_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hunt_restart | input | 1 | Synchronous pulse that restarts the hunt |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifies `bit_in` on this clock |
| mode | input | 2 | 0 single pattern, 1 double pattern, 2 flag, 3 external |
| rate_sel | input | 2 | Selects the external-mode variant, ignored in other modes |
| len6 | input | 1 | 1 selects 6-bit characters and patterns |
| strip_en | input | 1 | Drop boundary characters equal to `sync_sec` in mode 0 |
| sync_pri | input | CHAR_W | Primary sync pattern or flag value |
| sync_sec | input | CHAR_W | Secondary sync pattern / strip value |
| sync_n | input | 1 | Active-low external sync pin |
| char_out | output | CHAR_W | Last delivered character |
| char_vld | output | 1 | One-clock strobe for `char_out` |
| sync_ok | output | 1 | Character sync acquired |
| flag_pulse | output | 1 | One clock per flag seen or forced |

## Verification
The bench builds the block with its default widths, 8-bit characters and a 6-bit short length, so that both lengths of each pattern, the zero-extended 6-bit character and the 8-bit flag can all be reached. With these values each mode and each external variant can be tried with byte-sized patterns. It also covers a pin-forced flag that lands halfway through a character, and a bit gap in the middle of a character.

// File: rtl/hunt_pkg.sv
package hunt_pkg;

   typedef enum logic [1:0] {
      HM_SINGLE = 2'd0,
      HM_DOUBLE = 2'd1,
      HM_FLAG   = 2'd2,
      HM_EXT    = 2'd3
   } hunt_mode_e;

   typedef enum logic [1:0] {
      XR_PIN_A     = 2'd0,
      XR_PIN_B     = 2'd1,
      XR_PIN_OR_PAT = 2'd2,
      XR_PIN_FLAG  = 2'd3
   } ext_rate_e;

endpackage

// File: rtl/hunt_shifter.sv
module hunt_shifter #(
   parameter int WIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             shift,
   input  logic             din,
   output logic [WIN_W-1:0] win_nx
);

   logic [WIN_W-1:0] win_q;

   // newest bit enters at the top, so earlier bits drift toward bit 0
   assign win_nx = {din, win_q[WIN_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
      end else if (clr) begin
         win_q <= '0;
      end else if (shift) begin
         win_q <= win_nx;
      end
   end

endmodule

// File: rtl/hunt_matcher.sv
module hunt_matcher #(
   parameter int CHAR_W  = 8,
   parameter int SHORT_W = 6
) (
   input  logic [2*CHAR_W-1:0] win,
   input  logic [CHAR_W-1:0]   pat_a,
   input  logic [CHAR_W-1:0]   pat_b,
   input  logic                short_sel,
   output logic                hit_single,
   output logic                hit_double,
   output logic                hit_strip,
   output logic                hit_flag,
   output logic [CHAR_W-1:0]   cand
);

   localparam int WIN_W = 2 * CHAR_W;

   logic [1:0]        single_v;
   logic [1:0]        double_v;
   logic [1:0]        strip_v;
   logic [CHAR_W-1:0] cand_v [2];

   // index 0 = full length, index 1 = short length
   for (genvar k = 0; k < 2; k++) begin : g_len
      localparam int L = (k == 0) ? CHAR_W : SHORT_W;
      logic [L-1:0]   top_l;
      logic [2*L-1:0] top_2l;
      assign top_l      = win[WIN_W-1 -: L];
      assign top_2l     = win[WIN_W-1 -: 2*L];
      assign single_v[k] = (top_l == pat_a[L-1:0]);
      assign strip_v[k]  = (top_l == pat_b[L-1:0]);
      assign double_v[k] = (top_2l == {pat_b[L-1:0], pat_a[L-1:0]});
      if (L == CHAR_W) begin : g_full
         assign cand_v[k] = top_l;
      end else begin : g_ext
         assign cand_v[k] = {{(CHAR_W-L){1'b0}}, top_l};
      end
   end

   assign hit_single = short_sel ? single_v[1] : single_v[0];
   assign hit_double = short_sel ? double_v[1] : double_v[0];
   assign hit_strip  = short_sel ? strip_v[1]  : strip_v[0];
   assign cand       = short_sel ? cand_v[1]   : cand_v[0];
   // flags are always compared at full length
   assign hit_flag   = single_v[0];

endmodule

// File: rtl/hunt_framer.sv
module hunt_framer
   import hunt_pkg::*;
#(
   parameter int CHAR_W  = 8,
   parameter int SHORT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              bit_vld,
   input  hunt_mode_e        mode,
   input  ext_rate_e         rate,
   input  logic              short_sel,
   input  logic              strip_en,
   input  logic              pin_act,
   input  logic              hit_single,
   input  logic              hit_double,
   input  logic              hit_strip,
   input  logic              hit_flag,
   input  logic [CHAR_W-1:0] cand,
   output logic [CHAR_W-1:0] char_q,
   output logic              char_vld_q,
   output logic              sync_q,
   output logic              flag_q
);

   localparam int CNT_W = $clog2(CHAR_W + 1);
   localparam logic [CNT_W-1:0] LEN_FULL  = CNT_W'(CHAR_W);
   localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_W);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] len_cur;
   logic             flag_framing;
   logic             flag_evt;
   logic             acq_hit;
   logic             acq_evt;
   logic             realign;
   logic             at_boundary;
   logic             drop;

   assign flag_framing = (mode == HM_FLAG) ||
                         ((mode == HM_EXT) && (rate == XR_PIN_FLAG));

   always_comb begin
      acq_hit = 1'b0;
      unique case (mode)
         HM_SINGLE: acq_hit = hit_single;
         HM_DOUBLE: acq_hit = hit_double;
         HM_FLAG:   acq_hit = 1'b0;
         HM_EXT: begin
            if (rate == XR_PIN_OR_PAT) acq_hit = pin_act || hit_single;
            else                       acq_hit = pin_act;
         end
         default:   acq_hit = 1'b0;
      endcase
   end

   assign flag_evt = flag_framing &&
                     (hit_flag || ((mode == HM_EXT) && pin_act));
   assign acq_evt  = !flag_framing && !sync_q && acq_hit;
   assign realign  = flag_evt || acq_evt;

   assign len_cur     = short_sel ? LEN_SHORT : LEN_FULL;
   assign cnt_inc     = cnt_q + 1'b1;
   assign at_boundary = sync_q && (cnt_inc == len_cur);
   assign drop        = (mode == HM_SINGLE) && strip_en && hit_strip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         sync_q     <= 1'b0;
         char_q     <= '0;
         char_vld_q <= 1'b0;
         flag_q     <= 1'b0;
      end else if (restart) begin
         cnt_q      <= '0;
         sync_q     <= 1'b0;
         char_vld_q <= 1'b0;
         flag_q     <= 1'b0;
      end else begin
         char_vld_q <= 1'b0;
         flag_q     <= 1'b0;
         if (bit_vld) begin
            if (realign) begin
               cnt_q  <= '0;
               sync_q <= 1'b1;
               flag_q <= flag_evt;
            end else if (sync_q) begin
               if (at_boundary) begin
                  cnt_q <= '0;
                  if (!drop) begin
                     char_q     <= cand;
                     char_vld_q <= 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_inc;
               end
            end
         end
      end
   end

endmodule

// File: rtl/sync_hunter.sv
module sync_hunter
   import hunt_pkg::*;
#(
   parameter int CHAR_W  = 8,
   parameter int SHORT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hunt_restart,
   input  logic              bit_in,
   input  logic              bit_vld,
   input  logic [1:0]        mode,
   input  logic [1:0]        rate_sel,
   input  logic              len6,
   input  logic              strip_en,
   input  logic [CHAR_W-1:0] sync_pri,
   input  logic [CHAR_W-1:0] sync_sec,
   input  logic              sync_n,
   output logic [CHAR_W-1:0] char_out,
   output logic              char_vld,
   output logic              sync_ok,
   output logic              flag_pulse
);

   localparam int WIN_W = 2 * CHAR_W;

   if (CHAR_W < 2) begin : g_bad_char
      $error("CHAR_W must be at least 2");
   end
   if (SHORT_W < 1 || SHORT_W >= CHAR_W) begin : g_bad_short
      $error("SHORT_W must lie between 1 and CHAR_W-1");
   end

   logic [WIN_W-1:0]  win_nx;
   logic              hit_single;
   logic              hit_double;
   logic              hit_strip;
   logic              hit_flag;
   logic [CHAR_W-1:0] cand;

   hunt_shifter #(.WIN_W(WIN_W)) i_shifter (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (hunt_restart),
      .shift  (bit_vld),
      .din    (bit_in),
      .win_nx (win_nx)
   );

   hunt_matcher #(.CHAR_W(CHAR_W), .SHORT_W(SHORT_W)) i_matcher (
      .win        (win_nx),
      .pat_a      (sync_pri),
      .pat_b      (sync_sec),
      .short_sel  (len6),
      .hit_single (hit_single),
      .hit_double (hit_double),
      .hit_strip  (hit_strip),
      .hit_flag   (hit_flag),
      .cand       (cand)
   );

   hunt_framer #(.CHAR_W(CHAR_W), .SHORT_W(SHORT_W)) i_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (hunt_restart),
      .bit_vld    (bit_vld),
      .mode       (hunt_mode_e'(mode)),
      .rate       (ext_rate_e'(rate_sel)),
      .short_sel  (len6),
      .strip_en   (strip_en),
      .pin_act    (!sync_n),
      .hit_single (hit_single),
      .hit_double (hit_double),
      .hit_strip  (hit_strip),
      .hit_flag   (hit_flag),
      .cand       (cand),
      .char_q     (char_out),
      .char_vld_q (char_vld),
      .sync_q     (sync_ok),
      .flag_q     (flag_pulse)
   );

endmodule

// File: rtl/sync_hunter_chk.sv
module sync_hunter_chk #(
   parameter int CHAR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hunt_restart,
   input logic              bit_vld,
   input logic [1:0]        mode,
   input logic [1:0]        rate_sel,
   input logic              len6,
   input logic              strip_en,
   input logic [CHAR_W-1:0] sync_sec,
   input logic [CHAR_W-1:0] char_out,
   input logic              char_vld,
   input logic              sync_ok,
   input logic              flag_pulse
);

   AST_CHAR_ONLY_SYNCED: assert property (@(posedge clk) disable iff (!rst_n)
      char_vld |-> sync_ok);  // R3

   AST_STRIPPED_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (char_vld && $past(mode) == 2'd0 && $past(strip_en) && !$past(len6))
         |-> char_out != $past(sync_sec));  // R4

   AST_FLAG_FROM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      flag_pulse |-> $past(bit_vld));  // R5

   AST_FLAG_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      flag_pulse |-> ($past(mode) == 2'd2 ||
                      ($past(mode) == 2'd3 && $past(rate_sel) == 2'd3)));  // R8

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      hunt_restart |=> (!sync_ok && !char_vld && !flag_pulse));  // R10

   AST_SYNC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_ok && !hunt_restart) |=> sync_ok);  // R11

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld |=> (!char_vld && !flag_pulse));  // R12

   AST_IDLE_SYNC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_vld && !hunt_restart) |=> $stable(sync_ok));  // R12

endmodule

bind sync_hunter sync_hunter_chk #(.CHAR_W(CHAR_W)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hunt_restart (hunt_restart),
   .bit_vld      (bit_vld),
   .mode         (mode),
   .rate_sel     (rate_sel),
   .len6         (len6),
   .strip_en     (strip_en),
   .sync_sec     (sync_sec),
   .char_out     (char_out),
   .char_vld     (char_vld),
   .sync_ok      (sync_ok),
   .flag_pulse   (flag_pulse)
);

// File: tb/test_sync_hunter.sv
module test_sync_hunter;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hunt_restart = 1'b0;
   logic       bit_in = 1'b0;
   logic       bit_vld = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [1:0] rate_sel = 2'd0;
   logic       len6 = 1'b0;
   logic       strip_en = 1'b0;
   logic [7:0] sync_pri = 8'h00;
   logic [7:0] sync_sec = 8'h00;
   logic       sync_n = 1'b1;
   logic [7:0] char_out;
   logic       char_vld;
   logic       sync_ok;
   logic       flag_pulse;

   int errors = 0;
   int checks = 0;
   int n_chars = 0;
   int n_flags = 0;
   logic [7:0] chars [16];
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   sync_hunter i_sync_hunter (
      .clk(clk), .rst_n(rst_n), .hunt_restart(hunt_restart),
      .bit_in(bit_in), .bit_vld(bit_vld), .mode(mode), .rate_sel(rate_sel),
      .len6(len6), .strip_en(strip_en), .sync_pri(sync_pri),
      .sync_sec(sync_sec), .sync_n(sync_n), .char_out(char_out),
      .char_vld(char_vld), .sync_ok(sync_ok), .flag_pulse(flag_pulse)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input string what,
                         input int act, input int exp);
      chk(act == exp, req, what, act, exp);
   endtask

   // one valid bit, then one idle clock; outputs sampled after the edge
   task automatic send_bit(input logic b, input logic pin);
      @(negedge clk);
      bit_in  = b;
      bit_vld = 1'b1;
      sync_n  = !pin;
      @(negedge clk);
      bit_vld = 1'b0;
      sync_n  = 1'b1;
      if (char_vld) begin
         if (n_chars < 16) chars[n_chars] = char_out;
         n_chars++;
      end
      if (flag_pulse) n_flags++;
   endtask

   task automatic send_word(input logic [7:0] v, input int n);
      for (int i = 0; i < n; i++) send_bit(v[i], 1'b0);
   endtask

   task automatic restart_hunt();
      @(negedge clk);
      hunt_restart = 1'b1;
      @(negedge clk);
      hunt_restart = 1'b0;
      n_chars = 0;
      n_flags = 0;
   endtask

   task automatic t_reset();
      chk_eq("R10", "sync_ok after reset", sync_ok, 0);
      chk_eq("R10", "char_vld after reset", char_vld, 0);
      chk_eq("R10", "flag_pulse after reset", flag_pulse, 0);
   endtask

   task automatic t_single8();
      mode = 2'd0; rate_sel = 2'd3; len6 = 0; strip_en = 0; sync_pri = 8'h16;
      restart_hunt();
      send_word(8'h00, 8);
      send_word(8'h16, 7);
      chk_eq("R1", "sync_ok before last pattern bit", sync_ok, 0);
      send_bit(1'b0, 1'b0);
      chk_eq("R1", "sync_ok after 8-bit match", sync_ok, 1);
      chk_eq("R9", "sync_ok with rate_sel=3 in mode 0", sync_ok, 1);
      send_word(8'hA5, 4);
      begin
         bit saw = 1'b0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            bit_in = ~bit_in;
            if (char_vld || flag_pulse) saw = 1'b1;
         end
         chk_eq("R12", "strobe during idle gap", saw, 0);
      end
      chk_eq("R12", "sync_ok across gap", sync_ok, 1);
      for (int i = 4; i < 8; i++) send_bit(8'hA5 >> i, 1'b0);
      chk_eq("R3", "char count after gap", n_chars, 1);
      chk_eq("R3", "first char", chars[0], 8'hA5);
      send_word(8'h16, 8);
      chk_eq("R11", "repeated pattern as data count", n_chars, 2);
      chk_eq("R11", "repeated pattern as data value", chars[1], 8'h16);
   endtask

   task automatic t_single6();
      mode = 2'd0; rate_sel = 2'd0; len6 = 1; strip_en = 0; sync_pri = 8'h2D;
      restart_hunt();
      send_word(8'h00, 6);
      send_word(8'h2D, 6);
      chk_eq("R1", "sync_ok after 6-bit match", sync_ok, 1);
      send_word(8'h15, 6);
      send_word(8'h2A, 6);
      chk_eq("R3", "6-bit char count", n_chars, 2);
      chk_eq("R3", "6-bit char 0", chars[0], 8'h15);
      chk_eq("R3", "6-bit char 1", chars[1], 8'h2A);
   endtask

   task automatic t_strip();
      mode = 2'd0; rate_sel = 2'd0; len6 = 0; strip_en = 1;
      sync_pri = 8'h16; sync_sec = 8'h33;
      restart_hunt();
      send_word(8'h16, 8);
      send_word(8'h33, 8);
      chk_eq("R4", "stripped char not delivered", n_chars, 0);
      send_word(8'h44, 8);
      chk_eq("R4", "count after stripped char", n_chars, 1);
      chk_eq("R4", "char after strip", chars[0], 8'h44);
   endtask

   task automatic t_double16();
      mode = 2'd1; rate_sel = 2'd0; len6 = 0; strip_en = 1;
      sync_pri = 8'h12; sync_sec = 8'h34;
      restart_hunt();
      send_word(8'h12, 8);
      chk_eq("R2", "sync_ok after primary only", sync_ok, 0);
      send_word(8'h34, 8);
      chk_eq("R2", "sync_ok after 16-bit match", sync_ok, 1);
      send_word(8'h34, 8);
      chk_eq("R4", "no strip in mode 1 count", n_chars, 1);
      chk_eq("R4", "no strip in mode 1 value", chars[0], 8'h34);
   endtask

   task automatic t_double12();
      mode = 2'd1; rate_sel = 2'd0; len6 = 1; strip_en = 0;
      sync_pri = 8'h05; sync_sec = 8'h2A;
      restart_hunt();
      send_word(8'h05, 6);
      chk_eq("R2", "sync_ok after 6-bit primary", sync_ok, 0);
      send_word(8'h2A, 6);
      chk_eq("R2", "sync_ok after 12-bit match", sync_ok, 1);
      send_word(8'h3F, 6);
      chk_eq("R2", "char after 12-bit sync", chars[0], 8'h3F);
   endtask

   task automatic t_flag();
      mode = 2'd2; rate_sel = 2'd1; len6 = 0; strip_en = 0; sync_pri = 8'h7E;
      restart_hunt();
      send_word(8'h7E, 8);
      chk_eq("R5", "flag count after first flag", n_flags, 1);
      chk_eq("R5", "sync_ok after flag", sync_ok, 1);
      chk_eq("R5", "flag not delivered", n_chars, 0);
      @(negedge clk);
      chk_eq("R5", "flag_pulse one clock", flag_pulse, 0);
      send_word(8'hA1, 8);
      chk_eq("R5", "char after flag", chars[0], 8'hA1);
      send_word(8'h7E, 8);
      chk_eq("R5", "flag on boundary count", n_flags, 2);
      chk_eq("R5", "flag on boundary not a char", n_chars, 1);
      send_word(8'h05, 4);
      send_word(8'h7E, 8);
      chk_eq("R5", "off-boundary flag seen", n_flags, 3);
      send_word(8'hC3, 8);
      chk_eq("R5", "realigned char count", n_chars, 3);
      chk_eq("R9", "realigned char with rate_sel=1", chars[2], 8'hC3);
   endtask

   task automatic t_ext_pin();
      mode = 2'd3; rate_sel = 2'd0; len6 = 0; strip_en = 0; sync_pri = 8'h16;
      restart_hunt();
      send_word(8'h16, 8);
      chk_eq("R6", "pattern ignored with pin-only", sync_ok, 0);
      send_bit(1'b1, 1'b1);
      chk_eq("R6", "sync_ok after pin", sync_ok, 1);
      send_word(8'h5A, 8);
      chk_eq("R6", "char after pin count", n_chars, 1);
      chk_eq("R6", "char after pin", chars[0], 8'h5A);
      send_bit(1'b0, 1'b1);
      send_word(8'h16, 8);
      chk_eq("R11", "pin and pattern after sync as data", n_chars, 2);
   endtask

   task automatic t_ext_pat();
      mode = 2'd3; rate_sel = 2'd2; len6 = 0; strip_en = 0; sync_pri = 8'h16;
      restart_hunt();
      send_word(8'h16, 8);
      chk_eq("R7", "pattern sync in pin-or-pattern", sync_ok, 1);
      send_word(8'h5A, 8);
      chk_eq("R7", "char after pattern sync", chars[0], 8'h5A);
   endtask

   task automatic t_ext_flag();
      mode = 2'd3; rate_sel = 2'd3; len6 = 0; strip_en = 0; sync_pri = 8'h7E;
      restart_hunt();
      send_bit(1'b0, 1'b1);
      chk_eq("R8", "pin forced flag", n_flags, 1);
      chk_eq("R8", "sync_ok after forced flag", sync_ok, 1);
      send_word(8'h99, 8);
      chk_eq("R8", "char after forced flag", chars[0], 8'h99);
      send_word(8'h05, 3);
      send_bit(1'b0, 1'b1);
      chk_eq("R8", "second forced flag", n_flags, 2);
      send_word(8'h0F, 8);
      chk_eq("R8", "realigned char count", n_chars, 2);
      chk_eq("R8", "realigned char", chars[1], 8'h0F);
      send_word(8'h7E, 8);
      chk_eq("R8", "pattern flag in flag framing", n_flags, 3);
      chk_eq("R8", "pattern flag not a char", n_chars, 2);
   endtask

   task automatic t_restart();
      mode = 2'd0; rate_sel = 2'd0; len6 = 0; strip_en = 0; sync_pri = 8'h16;
      restart_hunt();
      send_word(8'h16, 8);
      chk_eq("R10", "sync before restart", sync_ok, 1);
      restart_hunt();
      chk_eq("R10", "sync_ok dropped by restart", sync_ok, 0);
      send_word(8'hA5, 8);
      chk_eq("R10", "no chars after restart", n_chars, 0);
      send_word(8'h16, 8);
      send_word(8'h3C, 8);
      chk_eq("R10", "char after new hunt", chars[0], 8'h3C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_single8();
      t_single6();
      t_strip();
      t_double16();
      t_double12();
      t_flag();
      t_ext_pin();
      t_ext_pat();
      t_ext_flag();
      t_restart();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule